// File: doc/BRIEF.md
# Serial EEPROM command front end

This block is the slave-side serial front end of a small byte-wide EEPROM. It oversamples the chip select, serial clock, serial data and pause pins on the system clock. It takes in an 8-bit instruction after chip select falls, decodes it, and gathers a byte address. For the 512-byte configuration, address bit 8 travels in bit 3 of the opcode. Read commands stream array bytes out MSB first from an incrementing address. Status reads stream the status byte supplied by a neighbour.

Write-type commands are not carried out here. The block raises single-cycle requests toward the neighbouring write-control and protection logic: set or clear write enable, store a status byte, store a data byte at a page-wrapped address, and a commit request when chip select rises. The array is a synchronous register file outside the block. The block drives its read address, and the data comes back one clock later. SO is driven only while the block is shifting data out. The output enable lets the pad release it to high impedance.

Top module: `sermem_cmd`

## Requirements
- R1: After reset, and whenever chip select is high, so_en_o is low and no request pulse is raised.
- R2: A command starts only after a high-to-low transition of cs_ni. Clocks received while cs_ni was already low at reset release have no effect.
- R3: SI is sampled on rising SCK edges and SO changes on falling SCK edges. Operation is identical whether SCK idles low or high.
- R4: Opcode 0000_A011 followed by an address byte streams bytes MSB first, starting at that address. The address advances by one after each byte and wraps from DEPTH-1 to 0.
- R5: When DEPTH is 512, bit 3 (A) of the read and write opcodes is address bit 8. For smaller depths that bit is ignored.
- R6: Opcode 0x05 streams stat_i repeatedly, MSB first, and is accepted even while wr_busy_i is high.
- R7: Any opcode other than 0x01, 0x04, 0x05, 0x06, 0000_x010 or 0000_x011 keeps so_en_o low and raises no request until the next chip select fall.
- R8: While wr_busy_i is high, every opcode except 0x05 is ignored: no request and no output.
- R9: HOLD falling while SCK is low pauses the transfer. During the pause so_en_o is low and SCK and SI are ignored. HOLD rising while SCK is low resumes exactly where the transfer stopped.
- R10: Opcode 0x06 pulses wel_set_o and opcode 0x04 pulses wel_clr_o, once each, when the eighth bit arrives.
- R11: After opcode 0000_A010 and an address byte, each complete data byte pulses wr_stb_o with wr_addr_o and wr_data_o. The low log2(PAGE) address bits then advance and wrap within the page.
- R12: After opcode 0x01, each complete data byte pulses stat_wr_o with that byte on wr_data_o.
- R13: commit_o pulses when chip select rises, but only after a write or status write that received at least one complete data byte and ended on a byte boundary.
- R14: Chip select rising ends a read at once. The next command starts afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | SO drive enable; low means high impedance |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| stat_i | input | 8 | Status byte to be shifted out |
| rd_addr_o | output | AW | Array read address |
| rd_data_i | input | 8 | Array read data, valid one clock after rd_addr_o |
| wel_set_o | output | 1 | Request to set the write enable latch |
| wel_clr_o | output | 1 | Request to clear the write enable latch |
| stat_wr_o | output | 1 | Request to store a status byte |
| wr_stb_o | output | 1 | Request to buffer a data byte |
| commit_o | output | 1 | Request to start the internal write cycle |
| wr_addr_o | output | AW | Address of the buffered data byte |
| wr_data_o | output | 8 | Data or status byte of the request |

## Verification
The assertions assume that the serial pins change slowly compared with clk_i, so that every SCK half period spans several system clocks, and that HOLD changes only while SCK is low. Under those conditions the pause and address-step properties describe real protocol events rather than glitches. The bench drives SCK with a half period of eight system clocks. It moves HOLD only after first taking SCK low, and it holds chip select steady for a full half period around each edge. Every stimulus therefore stays inside those assumptions in both clock polarities.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

  typedef enum logic [2:0] {
    ST_OP, ST_RADDR, ST_WADDR, ST_WDATA, ST_SDATA, ST_RDOUT, ST_STOUT, ST_IGN
  } st_e;

  typedef enum logic [2:0] {
    OPK_RD, OPK_WR, OPK_RDST, OPK_WRST, OPK_WEN, OPK_WDIS, OPK_BAD
  } opk_e;

  function automatic opk_e op_kind(input logic [7:0] op);
    if (op[7:4] != 4'h0) return OPK_BAD;
    case (op[3:0])
      4'b0110: return OPK_WEN;
      4'b0100: return OPK_WDIS;
      4'b0101: return OPK_RDST;
      4'b0001: return OPK_WRST;
      default: ;
    endcase
    // bit 3 is the high address bit for array access
    if (op[2:0] == 3'b011) return OPK_RD;
    if (op[2:0] == 3'b010) return OPK_WR;
    return OPK_BAD;
  endfunction

endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {2{RST_VAL[g]}};
      else         ff <= {ff[0], d_i[g]};
    end
    assign q_o[g] = ff[1];
  end
endmodule

// File: rtl/sermem_txsh.sv
module sermem_txsh (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic       shift_i,
  input  logic [7:0] din_i,
  output logic       so_o,
  output logic       act_o
);
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_o <= 1'b0;
    end else if (clr_i) begin
      sh_q  <= '0;
      act_o <= 1'b0;
    end else if (load_i) begin
      sh_q  <= din_i;
      act_o <= 1'b1;
    end else if (shift_i) begin
      sh_q  <= {sh_q[6:0], 1'b0};
    end
  end

  assign so_o = sh_q[7];
endmodule

// File: rtl/sermem_cmd.sv
module sermem_cmd
  import sermem_pkg::*;
#(
  parameter  int DEPTH = 512,
  parameter  int PAGE  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(PAGE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sck_i,
  input  logic          si_i,
  input  logic          hold_ni,
  output logic          so_o,
  output logic          so_en_o,
  input  logic          wr_busy_i,
  input  logic [7:0]    stat_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          wel_set_o,
  output logic          wel_clr_o,
  output logic          stat_wr_o,
  output logic          wr_stb_o,
  output logic          commit_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);
  // ctl = {cs, sck, hold}
  logic [2:0] ctl_q, ctl_p;
  logic       si_q;

  sermem_sync #(.W(3), .RST_VAL(3'b001)) i_sync_ctl (
    .clk_i, .rst_ni, .d_i({cs_ni, sck_i, hold_ni}), .q_o(ctl_q)
  );
  sermem_sync #(.W(1), .RST_VAL(1'b0)) i_sync_si (
    .clk_i, .rst_ni, .d_i(si_i), .q_o(si_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_p <= 3'b001;
    else         ctl_p <= ctl_q;
  end

  logic cs_s, cs_p, sck_s;
  logic cs_fall, cs_rise, sck_rise, sck_fall, hold_fall, hold_rise;
  assign cs_s      = ctl_q[2];
  assign cs_p      = ctl_p[2];
  assign sck_s     = ctl_q[1];
  assign cs_fall   = cs_p & ~cs_s;
  assign cs_rise   = ~cs_p & cs_s;
  assign sck_rise  = ~ctl_p[1] & ctl_q[1];
  assign sck_fall  = ctl_p[1] & ~ctl_q[1];
  assign hold_fall = ctl_p[0] & ~ctl_q[0];
  assign hold_rise = ~ctl_p[0] & ctl_q[0];

  st_e          st_q;
  logic         armed_q, paused_q, done_q, a8_q;
  logic [2:0]   bcnt_q, obit_q;
  logic [7:0]   sh_q;
  logic [AW-1:0] addr_q;

  logic       sel, rise_ev, fall_ev, is_out, tx_act, tx_load, tx_shift;
  logic [7:0] nxt;
  logic [8:0] full_addr;
  opk_e       kind;

  assign sel       = ~cs_s & armed_q;
  assign rise_ev   = sel & sck_rise & ~paused_q;
  assign fall_ev   = sel & sck_fall & ~paused_q;
  assign is_out    = (st_q == ST_RDOUT) || (st_q == ST_STOUT);
  assign nxt       = {sh_q[6:0], si_q};
  assign full_addr = {a8_q, nxt};
  assign kind      = op_kind(nxt);
  assign tx_load   = fall_ev & is_out & (obit_q == 3'd0);
  assign tx_shift  = fall_ev & is_out & (obit_q != 3'd0);
  assign rd_addr_o = addr_q;

  sermem_txsh i_txsh (
    .clk_i, .rst_ni,
    .clr_i  (~sel),
    .load_i (tx_load),
    .shift_i(tx_shift),
    .din_i  ((st_q == ST_RDOUT) ? rd_data_i : stat_i),
    .so_o   (so_o),
    .act_o  (tx_act)
  );

  assign so_en_o = tx_act & sel & ~paused_q & is_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_OP;
      armed_q   <= 1'b0;
      paused_q  <= 1'b0;
      done_q    <= 1'b0;
      a8_q      <= 1'b0;
      bcnt_q    <= '0;
      obit_q    <= '0;
      sh_q      <= '0;
      addr_q    <= '0;
      wel_set_o <= 1'b0;
      wel_clr_o <= 1'b0;
      stat_wr_o <= 1'b0;
      wr_stb_o  <= 1'b0;
      commit_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wel_set_o <= 1'b0;
      wel_clr_o <= 1'b0;
      stat_wr_o <= 1'b0;
      wr_stb_o  <= 1'b0;
      commit_o  <= cs_rise & armed_q & done_q & (bcnt_q == 3'd0) &
                   ((st_q == ST_WDATA) || (st_q == ST_SDATA));

      if (cs_fall)   armed_q <= 1'b1;
      else if (cs_s) armed_q <= 1'b0;

      if (!sel) begin
        st_q     <= ST_OP;
        bcnt_q   <= '0;
        obit_q   <= '0;
        done_q   <= 1'b0;
        paused_q <= 1'b0;
      end else begin
        // pause edges count only while SCK is low
        if (hold_fall && !sck_s)      paused_q <= 1'b1;
        else if (hold_rise && !sck_s) paused_q <= 1'b0;

        if (rise_ev) begin
          sh_q   <= nxt;
          bcnt_q <= bcnt_q + 3'd1;
          if (bcnt_q == 3'd7) begin
            case (st_q)
              ST_OP: begin
                if (kind == OPK_RDST)  st_q <= ST_STOUT;
                else if (wr_busy_i)    st_q <= ST_IGN;
                else begin
                  case (kind)
                    OPK_WEN:  begin wel_set_o <= 1'b1; st_q <= ST_IGN; end
                    OPK_WDIS: begin wel_clr_o <= 1'b1; st_q <= ST_IGN; end
                    OPK_WRST: st_q <= ST_SDATA;
                    OPK_RD:   begin a8_q <= (AW > 8) ? nxt[3] : 1'b0; st_q <= ST_RADDR; end
                    OPK_WR:   begin a8_q <= (AW > 8) ? nxt[3] : 1'b0; st_q <= ST_WADDR; end
                    default:  st_q <= ST_IGN;
                  endcase
                end
              end
              ST_RADDR: begin addr_q <= full_addr[AW-1:0]; st_q <= ST_RDOUT; end
              ST_WADDR: begin addr_q <= full_addr[AW-1:0]; st_q <= ST_WDATA; end
              ST_WDATA: begin
                wr_stb_o  <= 1'b1;
                wr_addr_o <= addr_q;
                wr_data_o <= nxt;
                done_q    <= 1'b1;
                addr_q    <= {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
              end
              ST_SDATA: begin
                stat_wr_o <= 1'b1;
                wr_data_o <= nxt;
                done_q    <= 1'b1;
              end
              default: ;
            endcase
          end
        end

        if (fall_ev && is_out) begin
          obit_q <= obit_q + 3'd1;
          if (tx_load && st_q == ST_RDOUT) addr_q <= addr_q + AW'(1);
        end
      end
    end
  end

  p_so_off_desel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_p |-> !so_en_o);
  p_ign_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IGN) |-> !so_en_o);
  p_pause_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_q |-> !so_en_o);
  p_pause_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_q && sel) |=> ($stable(bcnt_q) && $stable(sh_q)));
  p_rd_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load && st_q == ST_RDOUT) |=> (rd_addr_o == $past(rd_addr_o) + AW'(1)));
  p_page_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (addr_q[AW-1:PW] == wr_addr_o[AW-1:PW] &&
                  addr_q[PW-1:0] == wr_addr_o[PW-1:0] + PW'(1)));
  p_one_req_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wel_set_o, wel_clr_o, stat_wr_o, wr_stb_o, commit_o}));
endmodule

// File: tb/test_sermem_cmd.sv
module test_sermem_cmd;
  localparam int DEPTH = 512;
  localparam int PAGE  = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int HP    = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, sck, si, hold_n, so, so_en, busy;
  logic [7:0] stat_val, rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic wel_set, wel_clr, stat_wr, wr_stb, commit;
  logic cpol;

  sermem_cmd #(.DEPTH(DEPTH), .PAGE(PAGE)) i_sermem_cmd (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .so_o(so), .so_en_o(so_en), .wr_busy_i(busy),
    .stat_i(stat_val), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wel_set_o(wel_set), .wel_clr_o(wel_clr), .stat_wr_o(stat_wr),
    .wr_stb_o(wr_stb), .commit_o(commit), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  function automatic logic [7:0] fmem(input logic [AW-1:0] a);
    return a[7:0] + 8'h33 + (a[8] ? 8'h80 : 8'h00);
  endfunction

  always @(posedge clk) rd_data <= fmem(rd_addr);

  int n_set = 0, n_clr = 0, n_st = 0, n_wr = 0, n_cm = 0;
  logic [AW-1:0] wa [0:15];
  logic [7:0]    wd [0:15];
  logic [7:0]    sd;
  always @(posedge clk) if (rst_n) begin
    if (wel_set) n_set++;
    if (wel_clr) n_clr++;
    if (stat_wr) begin sd = wr_data; n_st++; end
    if (wr_stb)  begin wa[n_wr % 16] = wr_addr; wd[n_wr % 16] = wr_data; n_wr++; end
    if (commit)  n_cm++;
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic cs_lo();
    sck = cpol; w(HP); cs_n = 1'b0; w(HP);
  endtask

  task automatic cs_hi();
    sck = cpol; w(HP); cs_n = 1'b1; w(2*HP);
  endtask

  task automatic do_pause();
    sck = 1'b0; w(HP);
    hold_n = 1'b0; w(HP);
    chk("R9 so released in pause", so_en, 1'b0);
    repeat (3) begin si = ~si; sck = 1'b1; w(HP); sck = 1'b0; w(HP); end
    hold_n = 1'b1; w(HP);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic [7:0] en, input int pause_at);
    for (int i = 7; i >= 0; i--) begin
      if (i == pause_at) do_pause();
      sck = 1'b0; si = tx[i]; w(HP);
      rx[i] = so; en[i] = so_en;
      sck = 1'b1; w(HP);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx, en;
    xfer(tx, rx, en, 8);
  endtask

  task automatic t_reset();
    chk("R1 so_en after reset", so_en, 1'b0);
    chk("R1 no requests after reset", n_set + n_clr + n_st + n_wr + n_cm, 0);
  endtask

  task automatic t_noarm();
    logic [7:0] rx, en;
    send(8'h03); send(8'h10);
    xfer(8'h00, rx, en, 8);
    chk("R2 no output without cs fall", en, 8'h00);
    cs_n = 1'b1; w(2*HP);
  endtask

  task automatic t_read_mode0();
    logic [7:0] rx, en;
    cs_lo(); send(8'h03); send(8'h05);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, rx, en, 8);
      chk("R4 read byte mode 0", rx, fmem(AW'(5 + k)));
      chk("R3 so driven mode 0", en, 8'hFF);
    end
    cs_hi();
  endtask

  task automatic t_read_mode3();
    logic [7:0] rx, en;
    logic [AW-1:0] exp_a [0:2];
    exp_a[0] = 9'h1FE; exp_a[1] = 9'h1FF; exp_a[2] = 9'h000;
    cpol = 1'b1;
    cs_lo(); send(8'h0B); send(8'hFE);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, rx, en, 8);
      chk("R5 R4 R3 mode 3 read with A8 and wrap", rx, fmem(exp_a[k]));
    end
    cs_hi();
    cs_lo(); send(8'h03); send(8'hFE);
    xfer(8'h00, rx, en, 8);
    chk("R5 A8 clear selects low half", rx, fmem(9'h0FE));
    cs_hi();
    cpol = 1'b0;
  endtask

  task automatic t_status();
    logic [7:0] rx, en;
    busy = 1'b1; stat_val = 8'hA1;
    cs_lo(); send(8'h05);
    for (int k = 0; k < 2; k++) begin
      xfer(8'h00, rx, en, 8);
      chk("R6 status byte during busy", rx, 8'hA1);
      chk("R6 so driven", en, 8'hFF);
    end
    cs_hi();
    busy = 1'b0;
  endtask

  task automatic t_busy();
    logic [7:0] rx, en;
    int s0, w0, c0;
    s0 = n_set; w0 = n_wr; c0 = n_cm;
    busy = 1'b1;
    cs_lo(); send(8'h06); cs_hi();
    cs_lo(); send(8'h02); send(8'h10); send(8'h55); cs_hi();
    cs_lo(); send(8'h03); send(8'h00);
    xfer(8'h00, rx, en, 8);
    cs_hi();
    chk("R8 read ignored while busy", en, 8'h00);
    chk("R8 no requests while busy", (n_set - s0) + (n_wr - w0) + (n_cm - c0), 0);
    busy = 1'b0;
  endtask

  task automatic t_bad();
    logic [7:0] rx, en, en2;
    int tot;
    tot = n_set + n_clr + n_st + n_wr + n_cm;
    cs_lo(); send(8'h13);
    xfer(8'hFF, rx, en, 8);
    xfer(8'h00, rx, en2, 8);
    cs_hi();
    chk("R7 invalid opcode keeps so released", {en, en2}, 16'h0000);
    chk("R7 invalid opcode raises nothing", n_set + n_clr + n_st + n_wr + n_cm, tot);
    cs_lo(); send(8'h03); send(8'h20);
    xfer(8'h00, rx, en, 8);
    cs_hi();
    chk("R7 next cs fall recovers", rx, fmem(9'h020));
  endtask

  task automatic t_wel();
    int c0;
    c0 = n_cm;
    cs_lo(); send(8'h06); cs_hi();
    chk("R10 set request", n_set, 1);
    cs_lo(); send(8'h04); cs_hi();
    chk("R10 clear request", n_clr, 1);
    chk("R13 no commit for enable opcodes", n_cm, c0);
  endtask

  task automatic t_write();
    int w0, c0;
    logic [7:0] dat [0:2];
    logic [AW-1:0] adr [0:2];
    dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33;
    adr[0] = 9'h11E; adr[1] = 9'h11F; adr[2] = 9'h110;
    w0 = n_wr; c0 = n_cm;
    cs_lo(); send(8'h0A); send(8'h1E);
    for (int k = 0; k < 3; k++) send(dat[k]);
    cs_hi();
    chk("R11 byte count", n_wr - w0, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R11 page wrapped address", wa[(w0 + k) % 16], adr[k]);
      chk("R11 data", wd[(w0 + k) % 16], dat[k]);
    end
    chk("R13 commit after full write", n_cm - c0, 1);
  endtask

  task automatic t_partial();
    int w0, c0;
    w0 = n_wr; c0 = n_cm;
    cs_lo(); send(8'h02); send(8'h40); send(8'h77);
    for (int i = 0; i < 3; i++) begin sck = 1'b0; si = 1'b1; w(HP); sck = 1'b1; w(HP); end
    cs_hi();
    chk("R11 complete byte still buffered", n_wr - w0, 1);
    chk("R13 no commit off byte boundary", n_cm - c0, 0);
  endtask

  task automatic t_wrsr();
    int s0, c0;
    s0 = n_st; c0 = n_cm;
    cs_lo(); send(8'h01); send(8'h0C); cs_hi();
    chk("R12 status store request", n_st - s0, 1);
    chk("R12 status byte", sd, 8'h0C);
    chk("R13 commit after status write", n_cm - c0, 1);
  endtask

  task automatic t_hold();
    logic [7:0] rx, en;
    cs_lo(); send(8'h03);
    xfer(8'h40, rx, en, 3);
    xfer(8'h00, rx, en, 8);
    chk("R9 address intact across pause", rx, fmem(9'h040));
    xfer(8'h00, rx, en, 4);
    chk("R9 data resumes after pause", rx, fmem(9'h041));
    chk("R9 so driven after resume", en[3:0], 4'hF);
    cs_hi();
  endtask

  task automatic t_abort();
    logic [7:0] rx, en;
    cs_lo(); send(8'h03); send(8'h80);
    for (int i = 0; i < 4; i++) begin sck = 1'b0; w(HP); sck = 1'b1; w(HP); end
    cs_hi();
    chk("R14 so released after cs rise", so_en, 1'b0);
    cs_lo(); send(8'h03); send(8'h90);
    xfer(8'h00, rx, en, 8);
    cs_hi();
    chk("R14 new read starts afresh", rx, fmem(9'h090));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
    busy = 1'b0; stat_val = 8'h8C; cpol = 1'b0;
    w(5); rst_n = 1'b1; w(4);
    t_reset();
    t_noarm();
    t_read_mode0();
    t_read_mode3();
    t_status();
    t_busy();
    t_bad();
    t_wel();
    t_write();
    t_partial();
    t_wrsr();
    t_hold();
    t_abort();
    finish_run();
  end
endmodule